// File: doc/BRIEF.md
# Capability-Checked Address Translation Unit

This unit turns a 32-bit segmented virtual address into a physical word address. The upper half of the address is a segment selector. It holds a 4-bit capability-segment number in bits 31:28 and a 12-bit capability index in bits 27:16. Together these form a 16-bit key. The lower half is the word offset. The key is looked up in a fully associative store of evaluated capabilities. Each entry pairs a key with a physical base, a segment size, a segment kind (data or capability) and a set of access rights.

On a hit, the unit checks three things in order: that the requested operation suits the segment kind, that the rights allow it, and that the offset lies inside the segment. If all three pass, it returns base plus offset and updates the entry's written and used flags. On a miss, it raises a load request that carries the key. An external sequencer then writes the evaluated entry through the fill port, and the requester retries.

Every request receives exactly one registered response, one cycle later, with a single fault code.

Top module: `cap_xlate`

## Requirements
- R1: After reset the store holds no valid entry, `resp_valid` and `miss_req` are 0, and the first request to any key misses.
- R2: A request whose key (vaddr[31:16]) is not in the store gets, one cycle later, `resp_fault`=1 (miss), `miss_req`=1, `miss_key` equal to the key, `resp_paddr`=0 and `resp_flags`=0.
- R3: Fills go to store slots in round-robin order 0,1,...,ENTRIES-1 and then wrap. A fill into an occupied slot replaces it, so after ENTRIES+1 fills of distinct keys the first key misses and the second still hits.
- R4: On a data segment (`fill_is_cap`=0), op 0 (read) needs rights bit 2, op 1 (write) needs bit 1 and op 2 (execute) needs bit 0. Ops 3 and 4 are refused. A refusal gives `resp_fault`=2.
- R5: On a capability segment (`fill_is_cap`=1), op 3 (capability read) needs rights bit 3 and op 4 (capability write) needs rights bit 4. Any data op (0, 1 or 2) is refused with `resp_fault`=2, even when bit 4 is set. Op codes 5 to 7 are always refused.
- R6: If the offset (vaddr[15:0]) is greater than or equal to the entry size, the response is `resp_fault`=3 with `resp_paddr`=0.
- R7: A permitted, in-bounds request gives `resp_fault`=0 and `resp_paddr`=base+offset (modulo 2^PA_W), one cycle after the request.
- R8: Exactly one fault is reported per request, with priority miss > rights > bounds. Whenever `resp_valid`=0, both `resp_fault` and `miss_req` are 0.
- R9: `resp_flags`={W,U} shows the entry's flags after the request. A successful access sets U. A successful op 1 or op 4 also sets W. A faulting request leaves the flags unchanged, and a fill clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_op | input | 3 | Operation: 0 read, 1 write, 2 execute, 3 capability read, 4 capability write |
| req_vaddr | input | 32 | Virtual address: key in 31:16, offset in 15:0 |
| fill_valid | input | 1 | Write one evaluated entry |
| fill_key | input | 16 | Key of the filled entry |
| fill_base | input | PA_W | Physical base of the segment |
| fill_size | input | SZ_W | Segment size in words (0 to 65536) |
| fill_is_cap | input | 1 | 1 = capability segment, 0 = data segment |
| fill_rights | input | 5 | Rights: 4 cap write, 3 cap read, 2 read, 1 write, 0 execute |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_fault | output | 2 | 0 none, 1 miss, 2 rights, 3 bounds |
| resp_paddr | output | PA_W | Physical word address, 0 on fault |
| resp_flags | output | 2 | {W,U} of the entry after the request |
| miss_req | output | 1 | Load request to the sequencer |
| miss_key | output | 16 | Key to be loaded |

## Verification
On every cycle the assertions check the following. A response only follows a request. A faulting response never carries an address. A quiet cycle carries no fault and no load request. A fill always leaves its slot valid. The flags are only changed for an entry that actually hit, and a clean response always shows U set.

Only the bench's scenarios can show the rest. These are the rights decisions across every kind, rights and op combination; the exact bounds edge at size-1 and size; the round-robin eviction order; the fault priority; and the accumulated written and used flags. The bench checks each of these against a store model of its own.

// File: rtl/cap_xlate_pkg.sv
package cap_xlate_pkg;

    localparam int KEY_W  = 16;
    localparam int OFF_W  = 16;
    localparam int RGT_W  = 5;

    localparam logic [2:0] OP_RD  = 3'd0;
    localparam logic [2:0] OP_WR  = 3'd1;
    localparam logic [2:0] OP_EX  = 3'd2;
    localparam logic [2:0] OP_CRD = 3'd3;
    localparam logic [2:0] OP_CWR = 3'd4;

    localparam int RB_CWR = 4;
    localparam int RB_CRD = 3;
    localparam int RB_RD  = 2;
    localparam int RB_WR  = 1;
    localparam int RB_EX  = 0;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_MISS   = 2'd1,
        FLT_RIGHTS = 2'd2,
        FLT_BOUNDS = 2'd3
    } fault_e;

endpackage

// File: rtl/cap_store.sv
module cap_store
    import cap_xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PA_W    = 24,
    parameter int SZ_W    = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [KEY_W-1:0]         lk_key,
    output logic                     lk_hit,
    output logic [$clog2(ENTRIES)-1:0] lk_idx,
    output logic [PA_W-1:0]          lk_base,
    output logic [SZ_W-1:0]          lk_size,
    output logic                     lk_is_cap,
    output logic [RGT_W-1:0]         lk_rights,
    output logic [1:0]               lk_flags,
    input  logic                     upd_en,
    input  logic [$clog2(ENTRIES)-1:0] upd_idx,
    input  logic                     upd_w,
    input  logic                     fill_valid,
    input  logic [KEY_W-1:0]         fill_key,
    input  logic [PA_W-1:0]          fill_base,
    input  logic [SZ_W-1:0]          fill_size,
    input  logic                     fill_is_cap,
    input  logic [RGT_W-1:0]         fill_rights
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][KEY_W-1:0] key;
        logic [ENTRIES-1:0][PA_W-1:0]  base;
        logic [ENTRIES-1:0][SZ_W-1:0]  size;
        logic [ENTRIES-1:0]            is_cap;
        logic [ENTRIES-1:0][RGT_W-1:0] rights;
        logic [ENTRIES-1:0][1:0]       flags;
        logic [IDX_W-1:0]              rr;
    } store_t;

    store_t st_d, st_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = st_q.vld[g] && (st_q.key[g] == lk_key);
    end

    always_comb begin
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) lk_idx = IDX_W'(i);
        end
        lk_hit    = |match;
        lk_base   = st_q.base[lk_idx];
        lk_size   = st_q.size[lk_idx];
        lk_is_cap = st_q.is_cap[lk_idx];
        lk_rights = st_q.rights[lk_idx];
        lk_flags  = st_q.flags[lk_idx];
    end

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.flags[upd_idx] = st_q.flags[upd_idx] | {upd_w, 1'b1};
        end
        if (fill_valid) begin
            st_d.vld[st_q.rr]    = 1'b1;
            st_d.key[st_q.rr]    = fill_key;
            st_d.base[st_q.rr]   = fill_base;
            st_d.size[st_q.rr]   = fill_size;
            st_d.is_cap[st_q.rr] = fill_is_cap;
            st_d.rights[st_q.rr] = fill_rights;
            st_d.flags[st_q.rr]  = 2'b00;
            st_d.rr              = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> st_q.vld[$past(st_q.rr)]) else $error("fill slot not valid"); // R3

    AST_UPD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (lk_hit && upd_idx == lk_idx)) else $error("flag update without hit"); // R9

endmodule

// File: rtl/cap_check.sv
module cap_check
    import cap_xlate_pkg::*;
#(
    parameter int SZ_W = 17
) (
    input  logic             hit,
    input  logic [2:0]       op,
    input  logic             is_cap,
    input  logic [RGT_W-1:0] rights,
    input  logic [OFF_W-1:0] offset,
    input  logic [SZ_W-1:0]  size,
    output fault_e           fault,
    output logic             writes
);
    logic allowed;

    always_comb begin
        allowed = 1'b0;
        if (!is_cap) begin
            case (op)
                OP_RD:   allowed = rights[RB_RD];
                OP_WR:   allowed = rights[RB_WR];
                OP_EX:   allowed = rights[RB_EX];
                default: allowed = 1'b0;
            endcase
        end else begin
            case (op)
                OP_CRD:  allowed = rights[RB_CRD];
                OP_CWR:  allowed = rights[RB_CWR];
                default: allowed = 1'b0;
            endcase
        end

        if (!hit)                                   fault = FLT_MISS;
        else if (!allowed)                          fault = FLT_RIGHTS;
        else if (SZ_W'(offset) >= size)             fault = FLT_BOUNDS;
        else                                        fault = FLT_NONE;

        writes = (op == OP_WR) || (op == OP_CWR);
    end

endmodule

// File: rtl/cap_xlate.sv
module cap_xlate
    import cap_xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PA_W    = 24,
    parameter int SZ_W    = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [31:0]      req_vaddr,
    input  logic             fill_valid,
    input  logic [15:0]      fill_key,
    input  logic [PA_W-1:0]  fill_base,
    input  logic [SZ_W-1:0]  fill_size,
    input  logic             fill_is_cap,
    input  logic [4:0]       fill_rights,
    output logic             resp_valid,
    output logic [1:0]       resp_fault,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [1:0]       resp_flags,
    output logic             miss_req,
    output logic [15:0]      miss_key
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic             valid;
        fault_e           fault;
        logic [PA_W-1:0]  paddr;
        logic [1:0]       flags;
        logic             miss;
        logic [KEY_W-1:0] key;
    } resp_t;

    resp_t r_d, r_q;

    logic [KEY_W-1:0]  key;
    logic [OFF_W-1:0]  offset;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [PA_W-1:0]   lk_base;
    logic [SZ_W-1:0]   lk_size;
    logic              lk_is_cap;
    logic [RGT_W-1:0]  lk_rights;
    logic [1:0]        lk_flags;
    fault_e            chk_fault;
    logic              chk_writes;
    logic              upd_en;

    assign key    = req_vaddr[31:16];
    assign offset = req_vaddr[15:0];

    cap_store #(.ENTRIES(ENTRIES), .PA_W(PA_W), .SZ_W(SZ_W)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_key      (key),
        .lk_hit      (lk_hit),
        .lk_idx      (lk_idx),
        .lk_base     (lk_base),
        .lk_size     (lk_size),
        .lk_is_cap   (lk_is_cap),
        .lk_rights   (lk_rights),
        .lk_flags    (lk_flags),
        .upd_en      (upd_en),
        .upd_idx     (lk_idx),
        .upd_w       (chk_writes),
        .fill_valid  (fill_valid),
        .fill_key    (fill_key),
        .fill_base   (fill_base),
        .fill_size   (fill_size),
        .fill_is_cap (fill_is_cap),
        .fill_rights (fill_rights)
    );

    cap_check #(.SZ_W(SZ_W)) i_check (
        .hit    (lk_hit),
        .op     (req_op),
        .is_cap (lk_is_cap),
        .rights (lk_rights),
        .offset (offset),
        .size   (lk_size),
        .fault  (chk_fault),
        .writes (chk_writes)
    );

    assign upd_en = req_valid && (chk_fault == FLT_NONE);

    always_comb begin
        r_d = '0;
        if (req_valid) begin
            r_d.valid = 1'b1;
            r_d.fault = chk_fault;
            if (chk_fault == FLT_MISS) begin
                r_d.miss = 1'b1;
                r_d.key  = key;
            end else if (chk_fault == FLT_NONE) begin
                r_d.paddr = lk_base + PA_W'(offset);
                r_d.flags = lk_flags | {chk_writes, 1'b1};
            end else begin
                r_d.flags = lk_flags;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign resp_valid = r_q.valid;
    assign resp_fault = r_q.fault;
    assign resp_paddr = r_q.paddr;
    assign resp_flags = r_q.flags;
    assign miss_req   = r_q.miss;
    assign miss_key   = r_q.key;

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid)) else $error("response without request"); // R7

    AST_NO_ADDR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd0) |-> resp_paddr == '0) else $error("address on fault"); // R6

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_fault == 2'd0 && !miss_req)) else $error("fault while idle"); // R8

    AST_USED_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 2'd0) |-> resp_flags[0]) else $error("U not set"); // R9

endmodule

// File: tb/test_cap_xlate.sv
module test_cap_xlate;
    localparam int ENTRIES = 64;
    localparam int PA_W    = 24;
    localparam int SZ_W    = 17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_op = '0;
    logic [31:0]      req_vaddr = '0;
    logic             fill_valid = 1'b0;
    logic [15:0]      fill_key = '0;
    logic [PA_W-1:0]  fill_base = '0;
    logic [SZ_W-1:0]  fill_size = '0;
    logic             fill_is_cap = 1'b0;
    logic [4:0]       fill_rights = '0;
    logic             resp_valid;
    logic [1:0]       resp_fault;
    logic [PA_W-1:0]  resp_paddr;
    logic [1:0]       resp_flags;
    logic             miss_req;
    logic [15:0]      miss_key;

    int checks = 0;
    int failures = 0;

    logic [15:0]     m_key   [ENTRIES];
    logic            m_vld   [ENTRIES];
    logic [PA_W-1:0] m_base  [ENTRIES];
    logic [SZ_W-1:0] m_size  [ENTRIES];
    logic            m_cap   [ENTRIES];
    logic [4:0]      m_rgt   [ENTRIES];
    logic [1:0]      m_flg   [ENTRIES];
    int              m_rr = 0;

    always #10 clk = ~clk;

    cap_xlate #(.ENTRIES(ENTRIES), .PA_W(PA_W), .SZ_W(SZ_W)) i_cap_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_vaddr(req_vaddr), .fill_valid(fill_valid), .fill_key(fill_key),
        .fill_base(fill_base), .fill_size(fill_size), .fill_is_cap(fill_is_cap),
        .fill_rights(fill_rights), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .resp_flags(resp_flags), .miss_req(miss_req),
        .miss_key(miss_key)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(input logic [15:0] k);
        for (int i = 0; i < ENTRIES; i++) if (m_vld[i] && m_key[i] == k) return i;
        return -1;
    endfunction

    task automatic do_fill(input logic [15:0] k, input logic [PA_W-1:0] b, input logic [SZ_W-1:0] s,
                           input logic c, input logic [4:0] r);
        @(negedge clk);
        fill_valid = 1'b1; fill_key = k; fill_base = b; fill_size = s; fill_is_cap = c; fill_rights = r;
        @(negedge clk);
        fill_valid = 1'b0;
        m_vld[m_rr] = 1'b1; m_key[m_rr] = k; m_base[m_rr] = b; m_size[m_rr] = s;
        m_cap[m_rr] = c; m_rgt[m_rr] = r; m_flg[m_rr] = 2'b00;
        m_rr = (m_rr + 1) % ENTRIES;
    endtask

    task automatic do_req(input string tag, input logic [2:0] op, input logic [31:0] va);
        int idx;
        logic ok;
        logic [1:0] ef;
        logic [PA_W-1:0] ea;
        logic [1:0] efl;
        logic em;
        logic [15:0] ek;
        idx = find(va[31:16]);
        ea = '0; efl = 2'b00; em = 1'b0; ek = '0;
        if (idx < 0) begin
            ef = 2'd1; em = 1'b1; ek = va[31:16];
        end else begin
            if (!m_cap[idx])
                ok = (op == 3'd0 && m_rgt[idx][2]) || (op == 3'd1 && m_rgt[idx][1]) || (op == 3'd2 && m_rgt[idx][0]);
            else
                ok = (op == 3'd3 && m_rgt[idx][3]) || (op == 3'd4 && m_rgt[idx][4]);
            efl = m_flg[idx];
            if (!ok) ef = 2'd2;
            else if ({1'b0, va[15:0]} >= m_size[idx]) ef = 2'd3;
            else begin
                ef = 2'd0;
                ea = m_base[idx] + PA_W'(va[15:0]);
                efl = m_flg[idx] | {(op == 3'd1 || op == 3'd4), 1'b1};
                m_flg[idx] = efl;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "resp_valid", 32'(resp_valid), 32'd1);
        check(tag, "resp_fault", 32'(resp_fault), 32'(ef));
        check(tag, "resp_paddr", 32'(resp_paddr), 32'(ea));
        check(tag, "resp_flags", 32'(resp_flags), 32'(efl));
        check(tag, "miss_req",   32'(miss_req),   32'(em));
        check(tag, "miss_key",   32'(miss_key),   32'(ek));
    endtask

    initial begin
        #(20ns * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_vld[i] = 1'b0; m_key[i] = '0; m_base[i] = '0; m_size[i] = '0;
            m_cap[i] = 1'b0; m_rgt[i] = '0; m_flg[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset, first lookup misses
        check("R1", "resp_valid idle", 32'(resp_valid), 32'd0);
        check("R1", "miss_req idle", 32'(miss_req), 32'd0);
        check("R8", "resp_fault idle", 32'(resp_fault), 32'd0);
        do_req("R1", 3'd0, 32'h1234_0005);
        // R2: miss reports the key, then a fill makes it hit
        do_req("R2", 3'd1, 32'hA7FF_0010);
        do_fill(16'hA7FF, 24'h00_4000, 17'd64, 1'b0, 5'b00110);
        do_req("R7", 3'd1, 32'hA7FF_0010);
        do_req("R9", 3'd0, 32'hA7FF_003F);
        // R8: rights outranks bounds, miss outranks everything
        do_req("R8", 3'd2, 32'hA7FF_0100);
        do_req("R8", 3'd2, 32'hB000_0100);
        // R6: bounds edge on this entry
        do_req("R6", 3'd0, 32'hA7FF_0040);
        // R4/R5: every kind and rights combination, every op plus illegal ones
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 32; r++) begin
                if (c == 0 && r == 0) continue;
                do_fill(16'h0100 + 16'(c * 32 + r), PA_W'((c * 32 + r) * 256), 17'd100, c[0], r[4:0]);
            end
        end
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 32; r++) begin
                for (int op = 0; op < 8; op++) begin
                    if (c == 0 && r == 0) continue;
                    do_req(c == 0 ? "R4/R9" : "R5/R9", 3'(op), {16'h0100 + 16'(c * 32 + r), 16'(op * 3 + r)});
                end
            end
        end
        // R3: store is full; next fill evicts the first filled key
        do_req("R3", 3'd0, 32'h1234_0000);
        do_fill(16'h5555, 24'hFF_FFF0, 17'd65536, 1'b0, 5'b00100);
        do_req("R3", 3'd0, 32'hA7FF_0001);
        do_req("R3", 3'd3, 32'h0120_0002);
        // R6/R7: full-size segment, address wrap, exact bound
        do_req("R7", 3'd0, 32'h5555_0020);
        do_req("R6", 3'd0, 32'h5555_FFFF);
        do_fill(16'h6666, 24'h00_1000, 17'd16, 1'b0, 5'b00111);
        for (int off = 0; off < 20; off++) do_req("R6", 3'd2, {16'h6666, 16'(off)});
        do_fill(16'h7777, 24'h00_2000, 17'd0, 1'b1, 5'b11000);
        do_req("R6", 3'd3, 32'h7777_0000);
        do_req("R5", 3'd1, 32'h7777_0000);
        do_req("R9", 3'd4, 32'h7777_0000);
        check("R8", "resp_valid after", 32'(resp_valid), 32'd1);
        @(negedge clk);
        check("R8", "resp_valid drop", 32'(resp_valid), 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule